// File: doc/BRIEF.md
# Mirrored Bit-Mapped Display Memory for a Segment Driver

This block is the pixel store of a 160-segment dot-matrix LCD driver. A host writes bytes into a bit-mapped array organised as 100 rows of forty 8-bit groups (320 bits per row). The most significant bit of each byte is the leftmost position on the panel. A scan port reads one row back to the segment drivers as a stream of byte-wide beats, one beat per clock. In gray-scale mode each beat carries four 2-bit levels. In monochrome mode each beat carries eight 1-bit dots.

A mirror control reverses the left-to-right mapping. Group 0 then lands at the far segment end and the pixels inside each byte are emitted in reverse order. In gray-scale mode each 2-bit level keeps its odd-numbered bit as the more significant bit. The mirror control lets the same memory image appear the right way round whichever side of the panel the driver sits on. The mode and mirror inputs are captured when a scan starts and hold for the whole row.

Top module: `lcdram_mirror`

## Requirements
- R1: A write with wr_en high stores wr_data at group wr_group of row wr_row. The byte is returned by a later scan of that row. Memory contents are not cleared by reset.
- R2: Gray-scale, unmirrored: 40 beats, and beat k carries group k. Bits [2i+1:2i] of seg_data hold segment 4k+i+1 (i = 0..3), taken from stored bits [7-2i:6-2i]. So segment 1 gets bits 7:6 of group 0.
- R3: Gray-scale, mirrored: beat k carries group 39-k. Bits [2i+1:2i] of seg_data hold stored bits [2i+1:2i] unchanged. So segment 157 gets bits 1:0 and segment 160 gets bits 7:6 of group 0, and each pair keeps its odd bit as the MSB.
- R4: Monochrome, unmirrored: 20 beats covering the first 20 groups. Bit j of seg_data is segment 8k+j+1 and carries stored bit 7-j of group k.
- R5: Monochrome, mirrored: beat k carries group 19-k. Bit j of seg_data is stored bit j, so the 160-dot line is fully reversed.
- R6: When scan_start is sampled high on an idle block, beat 0 is valid in the next cycle. Beats follow on consecutive cycles. seg_last is high with the final beat (the 40th in gray, the 20th in monochrome). seg_valid is low in the cycle after the last beat.
- R7: A write with wr_group above 39 or wr_row above 99 changes no stored byte.
- R8: If a write and a scan read hit the same location in the same cycle, the scan beat shows the old byte. The new byte is stored and seen by later scans.
- R9: mode_mono (1 = monochrome) and mirror are sampled with scan_start. Changing them during a scan does not alter that scan.
- R10: scan_start is ignored while a scan is in progress, while its final beat is showing, and whenever scan_row is above 99.
- R11: After reset seg_valid and seg_last are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_group | input | 6 | Host byte-group address (0 to 39) |
| wr_row | input | 7 | Host row address (0 to 99) |
| wr_data | input | 8 | Host write byte, bit 7 leftmost |
| mode_mono | input | 1 | 1 = monochrome, 0 = gray-scale; sampled at scan start |
| mirror | input | 1 | 1 = reversed horizontal mapping; sampled at scan start |
| scan_start | input | 1 | One-cycle request to stream a row |
| scan_row | input | 7 | Row to stream, sampled with scan_start |
| seg_valid | output | 1 | Beat on seg_data is valid |
| seg_last | output | 1 | Final beat of the row |
| seg_data | output | 8 | Segment values in ascending segment order |

## Verification
A host write and a scan read can fall in the same cycle, and can hit the same byte. The bench provokes this by timing a write so that the write and the scan's read of the targeted group are sampled on the same clock edge. It does this for an unmirrored gray scan and a mirrored monochrome scan. The colliding beat must show the old byte, and a second scan of the row must show the new one. Mode and mirror inputs are also toggled mid-scan, and a second start is issued mid-scan, to show that neither disturbs the row in flight.

// File: rtl/lcdram_pkg.sv
package lcdram_pkg;
    localparam int LCD_GROUPS = 40;
    localparam int LCD_ROWS   = 100;
    localparam int LCD_GW     = 8;

    typedef enum logic {
        SCAN_GRAY = 1'b0,
        SCAN_MONO = 1'b1
    } scan_mode_e;
endpackage

// File: rtl/lcdram_store.sv
module lcdram_store #(
    parameter int GROUPS = lcdram_pkg::LCD_GROUPS,
    parameter int ROWS   = lcdram_pkg::LCD_ROWS,
    parameter int GW     = lcdram_pkg::LCD_GW,
    localparam int GAW   = $clog2(GROUPS),
    localparam int RW    = $clog2(ROWS),
    localparam int DEPTH = GROUPS * ROWS,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [GAW-1:0] wgrp,
    input  logic [RW-1:0]  wrow,
    input  logic [GW-1:0]  wdata,
    input  logic [GAW-1:0] rgrp,
    input  logic [RW-1:0]  rrow,
    output logic [GW-1:0]  rdata
);
    localparam logic [GAW-1:0] GMAX = GAW'(GROUPS - 1);
    localparam logic [RW-1:0]  RMAX = RW'(ROWS - 1);

    logic [GW-1:0] mem [DEPTH];
    logic          wr_ok;
    logic [IW-1:0] widx;
    logic [IW-1:0] ridx;
    logic [GW-1:0] rdata_q;

    always_comb begin
        wr_ok = we && (wgrp <= GMAX) && (wrow <= RMAX);
        widx  = IW'(wrow) * IW'(GROUPS) + IW'(wgrp);
        ridx  = IW'(rrow) * IW'(GROUPS) + IW'(rgrp);
    end

    // Read samples the array before this edge's write lands: old data on collision.
    always_ff @(posedge clk) begin
        rdata_q <= mem[ridx];
        if (wr_ok) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/lcdram_scan_ctrl.sv
module lcdram_scan_ctrl #(
    parameter int GROUPS = lcdram_pkg::LCD_GROUPS,
    parameter int ROWS   = lcdram_pkg::LCD_ROWS,
    localparam int GAW   = $clog2(GROUPS),
    localparam int RW    = $clog2(ROWS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [RW-1:0]  row,
    input  logic           mono,
    input  logic           mirror,
    output logic [GAW-1:0] rd_grp,
    output logic [RW-1:0]  rd_row,
    output logic           beat_valid,
    output logic           beat_last,
    output logic           beat_mono,
    output logic           beat_mirror
);
    import lcdram_pkg::*;

    localparam logic [RW-1:0]  RMAX      = RW'(ROWS - 1);
    localparam logic [GAW-1:0] FULL_LAST = GAW'(GROUPS - 1);
    localparam logic [GAW-1:0] HALF_LAST = GAW'(GROUPS / 2 - 1);

    typedef struct packed {
        logic           act;
        logic [GAW-1:0] cnt;
        logic [RW-1:0]  row;
        scan_mode_e     mode;
        logic           mir;
        logic           pv;
        logic           pl;
        scan_mode_e     pmode;
        logic           pmir;
    } ctrl_t;

    ctrl_t          d, q;
    logic [GAW-1:0] last_idx;
    logic           final_rd;

    always_comb begin
        last_idx = (q.mode == SCAN_MONO) ? HALF_LAST : FULL_LAST;
        final_rd = q.act && (q.cnt == last_idx);
        d        = q;
        d.pv     = q.act;
        d.pl     = final_rd;
        d.pmode  = q.mode;
        d.pmir   = q.mir;
        if (q.act) begin
            if (final_rd) begin
                d.act = 1'b0;
            end else begin
                d.cnt = q.cnt + GAW'(1);
            end
        end else if (start && !q.pv && (row <= RMAX)) begin
            d.act  = 1'b1;
            d.cnt  = '0;
            d.row  = row;
            d.mode = mono ? SCAN_MONO : SCAN_GRAY;
            d.mir  = mirror;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_grp      = q.mir ? (last_idx - q.cnt) : q.cnt;
        rd_row      = q.row;
        beat_valid  = q.pv;
        beat_last   = q.pl;
        beat_mono   = (q.pmode == SCAN_MONO);
        beat_mirror = q.pmir;
    end

    // R9: captured row settings stay fixed across a scan
    a_r9_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act && $past(q.act)) |-> ($stable(q.mode) && $stable(q.mir) && $stable(q.row)));

    // R10: an active scan runs on until its final read
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act && !final_rd) |=> (q.act && q.cnt == $past(q.cnt) + GAW'(1)));
endmodule

// File: rtl/lcdram_lane_fmt.sv
module lcdram_lane_fmt #(
    parameter int GW  = lcdram_pkg::LCD_GW,
    localparam int PIX = GW / 2
) (
    input  logic [GW-1:0] din,
    input  logic          mono,
    input  logic          mirror,
    output logic [GW-1:0] dout
);
    logic [GW-1:0] gray_fwd;
    logic [GW-1:0] mono_fwd;

    for (genvar i = 0; i < PIX; i++) begin : g_pair
        assign gray_fwd[2*i +: 2] = din[GW-2-2*i +: 2];
    end

    for (genvar j = 0; j < GW; j++) begin : g_dot
        assign mono_fwd[j] = din[GW-1-j];
    end

    // Mirrored output is the stored byte as-is in both modes.
    always_comb begin
        if (mirror) begin
            dout = din;
        end else if (mono) begin
            dout = mono_fwd;
        end else begin
            dout = gray_fwd;
        end
    end
endmodule

// File: rtl/lcdram_mirror.sv
module lcdram_mirror #(
    parameter int GROUPS = lcdram_pkg::LCD_GROUPS,
    parameter int ROWS   = lcdram_pkg::LCD_ROWS,
    parameter int GW     = lcdram_pkg::LCD_GW,
    localparam int GAW   = $clog2(GROUPS),
    localparam int RW    = $clog2(ROWS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [GAW-1:0] wr_group,
    input  logic [RW-1:0]  wr_row,
    input  logic [GW-1:0]  wr_data,
    input  logic           mode_mono,
    input  logic           mirror,
    input  logic           scan_start,
    input  logic [RW-1:0]  scan_row,
    output logic           seg_valid,
    output logic           seg_last,
    output logic [GW-1:0]  seg_data
);
    logic [GAW-1:0] rd_grp;
    logic [RW-1:0]  rd_row;
    logic [GW-1:0]  rd_byte;
    logic           bv, bl, bmono, bmir;

    lcdram_scan_ctrl #(.GROUPS(GROUPS), .ROWS(ROWS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(scan_start), .row(scan_row),
        .mono(mode_mono), .mirror(mirror), .rd_grp(rd_grp), .rd_row(rd_row),
        .beat_valid(bv), .beat_last(bl), .beat_mono(bmono), .beat_mirror(bmir)
    );

    lcdram_store #(.GROUPS(GROUPS), .ROWS(ROWS), .GW(GW)) u_store (
        .clk(clk), .we(wr_en), .wgrp(wr_group), .wrow(wr_row), .wdata(wr_data),
        .rgrp(rd_grp), .rrow(rd_row), .rdata(rd_byte)
    );

    lcdram_lane_fmt #(.GW(GW)) u_fmt (
        .din(rd_byte), .mono(bmono), .mirror(bmir), .dout(seg_data)
    );

    assign seg_valid = bv;
    assign seg_last  = bl;

    // Beat counter for checking the row length
    logic [GAW:0] beats_d, beats_q;
    always_comb begin
        beats_d = beats_q;
        if (seg_valid) begin
            beats_d = seg_last ? '0 : beats_q + (GAW+1)'(1);
        end
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else begin
            beats_q <= beats_d;
        end
    end

    a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        seg_last |-> seg_valid);

    a_r6_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_last) |=> seg_valid);

    a_r6_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        seg_last |=> !seg_valid);

    a_r6_row_length: assert property (@(posedge clk) disable iff (!rst_n)
        seg_last |-> (beats_q + (GAW+1)'(1) == (bmono ? (GAW+1)'(GROUPS/2) : (GAW+1)'(GROUPS))));
endmodule

// File: tb/lcdram_mirror_test.sv
`timescale 1ns/1ps
module lcdram_mirror_test;
    localparam int G = 40;
    localparam int R = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_group = '0;
    logic [6:0] wr_row = '0;
    logic [7:0] wr_data = '0;
    logic       mode_mono = 1'b0;
    logic       mirror = 1'b0;
    logic       scan_start = 1'b0;
    logic [6:0] scan_row = '0;
    logic       seg_valid, seg_last;
    logic [7:0] seg_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [G*R];

    always #2.5 clk = ~clk;

    lcdram_mirror uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_group(wr_group),
        .wr_row(wr_row), .wr_data(wr_data), .mode_mono(mode_mono),
        .mirror(mirror), .scan_start(scan_start), .scan_row(scan_row),
        .seg_valid(seg_valid), .seg_last(seg_last), .seg_data(seg_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pattern(input int g, input int r);
        return 8'((g * 37 + r * 11 + 5) & 255);
    endfunction

    // Expected beat derived per segment from the panel mapping.
    function automatic logic [7:0] exp_beat(input int row, input bit mono, input bit mir, input int k);
        logic [7:0] v = '0;
        if (!mono) begin
            for (int i = 0; i < 4; i++) begin
                int s = 4 * k + i + 1;
                int n = mir ? 161 - s : s;
                int p = (n - 1) % 4;
                logic [7:0] b = model[row * G + (n - 1) / 4];
                v[2*i +: 2] = 2'((b >> (6 - 2 * p)) & 3);
            end
        end else begin
            for (int j = 0; j < 8; j++) begin
                int s = 8 * k + j + 1;
                int n = mir ? 161 - s : s;
                logic [7:0] b = model[row * G + (n - 1) / 8];
                v[j] = b[7 - (n - 1) % 8];
            end
        end
        return v;
    endfunction

    task automatic host_write(input int g, input int r, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_group = 6'(g); wr_row = 7'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // coll_k >= 0 writes coll_d to the group read for beat coll_k in the same cycle (R8).
    // Settings are flipped and a second start issued mid-scan (R9, R10).
    task automatic scan(input int row, input bit mono, input bit mir, input int coll_k, input logic [7:0] coll_d);
        int n = mono ? 20 : 40;
        int cg = 0;
        string tg;
        tg = mono ? (mir ? "R5" : "R4") : (mir ? "R3" : "R2");
        if (coll_k >= 0) cg = mir ? (n - 1 - coll_k) : coll_k;
        @(negedge clk);
        scan_start = 1'b1; scan_row = 7'(row); mode_mono = mono; mirror = mir;
        for (int j = 0; j <= n + 1; j++) begin
            @(negedge clk);
            if (j == 0) scan_start = 1'b0;
            if (j == 2) begin mode_mono = !mono; mirror = !mir; end
            if (j == 3) begin scan_start = 1'b1; scan_row = 7'((row + 1) % R); end
            if (j == 4) scan_start = 1'b0;
            wr_en = 1'b0;
            if (j == coll_k) begin
                wr_en = 1'b1; wr_group = 6'(cg); wr_row = 7'(row); wr_data = coll_d;
            end
            if (j == 0 || j == n + 1) begin
                chk(!seg_valid && !seg_last, "R6 R10 no beat outside scan window",
                    {seg_valid, seg_last}, 0);
            end else begin
                logic [7:0] e = exp_beat(row, mono, mir, j - 1);
                chk(seg_valid === 1'b1 && seg_last === (j == n), "R6 valid/last timing",
                    {seg_valid, seg_last}, {1'b1, (j == n)});
                chk(seg_data === e,
                    $sformatf("%s R9 R10 row %0d beat %0d%s", tg, row, j - 1,
                              (j - 1 == coll_k) ? " R8 collision keeps old" : ""),
                    seg_data, e);
            end
        end
        wr_en = 1'b0; mode_mono = 1'b0; mirror = 1'b0;
        if (coll_k >= 0) model[row * G + cg] = coll_d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R6 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!seg_valid && !seg_last, "R11 reset outputs low", {seg_valid, seg_last}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!seg_valid && !seg_last, "R11 idle after reset", {seg_valid, seg_last}, 0);

        // R1: fill every location
        for (int r = 0; r < R; r++) begin
            for (int g = 0; g < G; g++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_group = 6'(g); wr_row = 7'(r); wr_data = pattern(g, r);
                model[r * G + g] = pattern(g, r);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;

        // R1..R5: all mode/mirror combinations on several rows
        foreach (model[i]) if (i < 0) model[i] = '0;
        for (int t = 0; t < 3; t++) begin
            int row = (t == 0) ? 0 : (t == 1) ? 57 : 99;
            for (int m = 0; m < 4; m++) begin
                scan(row, m[1], m[0], -1, 8'h00);
            end
        end

        // R7: out-of-range writes change nothing
        host_write(40, 0, 8'hA5);
        host_write(63, 5, 8'h5A);
        host_write(0, 100, 8'hC3);
        host_write(39, 127, 8'h3C);
        scan(1, 1'b0, 1'b0, -1, 8'h00);
        scan(6, 1'b0, 1'b0, -1, 8'h00);
        scan(99, 1'b0, 1'b1, -1, 8'h00);
        scan(0, 1'b0, 1'b0, -1, 8'h00);

        // R8: same-cycle write and scan read
        scan(33, 1'b0, 1'b0, 7, 8'hE1);
        scan(33, 1'b0, 1'b0, -1, 8'h00);
        scan(44, 1'b1, 1'b1, 3, 8'h96);
        scan(44, 1'b1, 1'b1, -1, 8'h00);
        scan(44, 1'b0, 1'b1, -1, 8'h00);

        // R10: start with row above 99 is ignored
        @(negedge clk);
        scan_start = 1'b1; scan_row = 7'd100;
        @(negedge clk);
        scan_start = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk(!seg_valid, "R10 out-of-range row start ignored", seg_valid, 0);
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule